// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block carries one I2C master message at a time, under the control of a small register port. Software loads a receive count, a transmit count, a first address byte and an optional second address byte, fills the transmit queue, and writes a start command. The block then has a bit-timing engine produce a START condition, the address byte or bytes, and the data bytes. Data moves between the bus and an 8-entry transmit queue or an 8-entry receive queue. When the message is finished the block does not release the bus. It reports "message done" and waits. A separate stop command makes the engine produce STOP and reports its own completion.

SCL and SDA timing lives in a separate bit-timing engine. This block talks to it through a request/done handshake that carries one operation: START, write byte, read byte or STOP. Events are recorded in a sticky status word. A per-bit enable mask decides which events set a single pending-interrupt flag, and that flag drives the interrupt output.

Top module: `i2cm_msg_seq`

## Requirements
- R1: After reset the busy bit (bit 3 of the command register) is 0, the status word is 0, both queue levels are 0 and `irq` is low.
- R2: Writing code 0x8 to the command register while idle, with exactly one of the two counts nonzero, starts a message. The engine is asked for START (op 0), then the first address byte as a write (op 1), then the data bytes. Busy reads 1 until the message ends. At the end status bit 11 (message done) is set and no STOP (op 3) is requested.
- R3: When bits 7:3 of the first address byte are 11110, the second address byte is written immediately after it. Otherwise only the first address byte is sent.
- R4: For a write (transmit count nonzero), the bytes are taken from the transmit queue in the order they were written and are sent as op 1. The transmit done counter (register 10) ends equal to the number of bytes the target acknowledged.
- R5: For a read (receive count nonzero), each byte is requested as op 2 and stored in the receive queue in order. The master-ACK output is 1 for every byte except the last, where it is 0.
- R6: A NAK during an address byte sets status bit 4. A NAK during a write data byte sets bit 5. Lost arbitration sets bit 6. In each case the message stops at once, busy clears and no further operation is requested.
- R7: A start command with both counts zero, a start command with both counts nonzero, or any command code other than 0x8 and 0xB (for example 0x9) sets status bit 8. None of these requests anything from the engine.
- R8: Command code 0xB requests STOP (op 3). Status bit 9 is set when the engine reports it done, and busy then clears.
- R9: Rewriting the receive count while a read is in progress changes the number of bytes read. The NAK moves to the new last byte.
- R10: Status bit 13 is 1 exactly while the receive queue holds data. Status bit 12 is 1 while a write is busy, the bytes already sent plus the bytes queued are fewer than the transmit count, and the queue has a free entry.
- R11: Status bits 11:4 stay set until software writes 1 to them at register 7. The pending flag (register 9 bit 0, also the `irq` output) is set when an enabled event fires (register 8 mask; for bits 12 and 13 the event is the rising edge) and is cleared by writing 1 to it. Masked events do not set it.
- R12: Each queue holds 8 bytes. A write to the data register (5) while the transmit queue is full is dropped. Register 6 gives the transmit level in bits 3:0 and the receive level in bits 11:8. A read of register 5 removes the oldest received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a byte when reading register 5) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Pending interrupt flag |
| eng_req | output | 1 | Operation request to the bit-timing engine, held until done |
| eng_op | output | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| eng_wbyte | output | 8 | Byte to write |
| eng_mack | output | 1 | 1 means the master ACKs the byte being read |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_nak | input | 1 | Target did not acknowledge (valid with done) |
| eng_arb | input | 1 | Arbitration was lost (valid with done) |
| eng_rbyte | input | 8 | Received byte (valid with done) |

## Verification
The handshake checks assume the engine raises `eng_done` only while `eng_req` is high. They also assume the request is never withdrawn before done. That second point holds only if software never writes a receive count below the bytes already read, and never changes the transmit count during a write. The bench's engine model accepts a request only when it is idle and not pulsing done. It always answers after a fixed latency. The stimulus extends the receive count and never shrinks it, and it reprograms counts only while the block is idle.

// File: rtl/i2cm_pkg.sv
// Shared types and constants of the I2C master message sequencer.
package i2cm_pkg;
    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2,
        BOP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_ADR1, SQ_ADR2, SQ_DATA, SQ_STOP
    } seq_state_e;

    localparam int REG_W = 16;

    // register indices
    localparam logic [3:0] RA_CMD    = 4'd0;
    localparam logic [3:0] RA_RXCNT  = 4'd1;
    localparam logic [3:0] RA_TXCNT  = 4'd2;
    localparam logic [3:0] RA_ADR1   = 4'd3;
    localparam logic [3:0] RA_ADR2   = 4'd4;
    localparam logic [3:0] RA_DATA   = 4'd5;
    localparam logic [3:0] RA_LEVEL  = 4'd6;
    localparam logic [3:0] RA_STAT   = 4'd7;
    localparam logic [3:0] RA_IEN    = 4'd8;
    localparam logic [3:0] RA_IPEND  = 4'd9;
    localparam logic [3:0] RA_TXDONE = 4'd10;
    localparam logic [3:0] RA_RXDONE = 4'd11;

    // status bit positions
    localparam int SB_RXSVC = 13;
    localparam int SB_TXSVC = 12;
    localparam int SB_MDONE = 11;
    localparam int SB_ADONE = 10;
    localparam int SB_STOP  = 9;
    localparam int SB_BADP  = 8;
    localparam int SB_TMO   = 7;
    localparam int SB_ARB   = 6;
    localparam int SB_NAKD  = 5;
    localparam int SB_NAKA  = 4;
endpackage

// File: rtl/i2cm_fifo.sv
// Byte queue with occupancy count.
// Assumes: a push while full and a pop while empty are dropped.
module i2cm_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/i2cm_seq.sv
// Message sequencer: START, one or two address bytes, data phase, and
// a separate STOP. Reports one-cycle event pulses to the status logic.
// Assumes: bus_done only while bus_req is high; counts are not lowered
// below the bytes already moved while busy.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             stop_go,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [7:0]       adr_first,
    input  logic [7:0]       adr_second,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    input  logic             rx_full,
    input  logic             bus_done,
    input  logic             bus_nak,
    input  logic             bus_arb,
    output logic             busy,
    output logic             rd_dir,
    output logic             bus_req,
    output bus_op_e          bus_op,
    output logic [7:0]       bus_wbyte,
    output logic             bus_mack,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [CNT_W-1:0] tx_done_cnt,
    output logic [CNT_W-1:0] rx_done_cnt,
    output logic             ev_mdone,
    output logic             ev_stop,
    output logic             ev_arb,
    output logic             ev_naka,
    output logic             ev_nakd
);
    seq_state_e st;
    logic ten_bit, data_left, data_room, in_adr;

    assign ten_bit   = (adr_first[7:3] == 5'b11110);
    assign data_left = rd_dir ? (rx_done_cnt < rx_cnt) : (tx_done_cnt < tx_cnt);
    assign data_room = rd_dir ? !rx_full : !tx_empty;
    assign in_adr    = (st == SQ_ADR1) || (st == SQ_ADR2);
    assign busy      = (st != SQ_IDLE);

    // engine request, operation and byte for the current state
    always_comb begin
        bus_req   = 1'b0;
        bus_op    = BOP_START;
        bus_wbyte = 8'h00;
        unique case (st)
            SQ_START: bus_req = 1'b1;
            SQ_ADR1:  begin bus_req = 1'b1; bus_op = BOP_WRITE; bus_wbyte = adr_first; end
            SQ_ADR2:  begin bus_req = 1'b1; bus_op = BOP_WRITE; bus_wbyte = adr_second; end
            SQ_DATA:  begin
                bus_req   = data_left && data_room;
                bus_op    = rd_dir ? BOP_READ : BOP_WRITE;
                bus_wbyte = rd_dir ? 8'h00 : tx_head;
            end
            SQ_STOP:  begin bus_req = 1'b1; bus_op = BOP_STOP; end
            default:  ;
        endcase
    end

    // the master ACKs unless this read is the last one requested
    assign bus_mack = ({1'b0, rx_done_cnt} + 1'b1) != {1'b0, rx_cnt};

    assign tx_pop   = (st == SQ_DATA) && !rd_dir && bus_done;
    assign rx_push  = (st == SQ_DATA) && rd_dir && bus_done && !bus_arb;
    assign ev_mdone = (st == SQ_DATA) && !data_left;
    assign ev_stop  = (st == SQ_STOP) && bus_done;
    assign ev_arb   = bus_done && bus_arb && (st != SQ_STOP) && busy;
    assign ev_naka  = bus_done && !bus_arb && bus_nak && in_adr;
    assign ev_nakd  = bus_done && !bus_arb && bus_nak && (st == SQ_DATA) && !rd_dir;

    // state, direction and byte counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            rd_dir      <= 1'b0;
            tx_done_cnt <= '0;
            rx_done_cnt <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start_go) begin
                        st          <= SQ_START;
                        rd_dir      <= (rx_cnt != '0);
                        tx_done_cnt <= '0;
                        rx_done_cnt <= '0;
                    end else if (stop_go) begin
                        st <= SQ_STOP;
                    end
                end
                SQ_START: if (bus_done) st <= bus_arb ? SQ_IDLE : SQ_ADR1;
                SQ_ADR1: if (bus_done) begin
                    if (bus_arb || bus_nak) st <= SQ_IDLE;
                    else                    st <= ten_bit ? SQ_ADR2 : SQ_DATA;
                end
                SQ_ADR2: if (bus_done) st <= (bus_arb || bus_nak) ? SQ_IDLE : SQ_DATA;
                SQ_DATA: begin
                    if (!data_left)     st <= SQ_IDLE;
                    else if (bus_done) begin
                        if (bus_arb)     st <= SQ_IDLE;
                        else if (rd_dir) rx_done_cnt <= rx_done_cnt + 1'b1;
                        else if (bus_nak) st <= SQ_IDLE;
                        else             tx_done_cnt <= tx_done_cnt + 1'b1;
                    end
                end
                SQ_STOP: if (bus_done) st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req); // R2
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |-> bus_req); // R2
    AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R12
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rd_dir |-> tx_done_cnt <= tx_cnt); // R4
endmodule

// File: rtl/i2cm_msg_seq.sv
// Top: register port, transmit and receive queues, sticky status,
// interrupt mask and pending flag around the message sequencer.
// Assumes: the bit-timing engine follows the req/done handshake.
module i2cm_msg_seq
    import i2cm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        eng_req,
    output logic [1:0]  eng_op,
    output logic [7:0]  eng_wbyte,
    output logic        eng_mack,
    input  logic        eng_done,
    input  logic        eng_nak,
    input  logic        eng_arb,
    input  logic [7:0]  eng_rbyte
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [CNT_W-1:0] rx_cnt_q, tx_cnt_q, tx_done, rx_done;
    logic [7:0]       adr1_q, adr2_q, tx_head, rx_head;
    logic [REG_W-1:0] en_q, status_w, set_vec;
    logic [11:4]      st_q, ev;
    logic [1:0]       svc_q;
    logic             pend_q, busy, rd_dir;
    logic             wr_cmd, cmd_go, stop_go, bad_cmd;
    logic             tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
    logic             tx_svc, rx_svc;
    logic             ev_mdone, ev_stop, ev_arb, ev_naka, ev_nakd;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic [CNT_W:0]   tx_sum;
    bus_op_e          op;

    // command decode; only accepted while idle
    assign wr_cmd  = reg_wr && (reg_addr == RA_CMD) && !busy;
    assign cmd_go  = wr_cmd && (reg_wdata[3:0] == 4'h8) && ((rx_cnt_q != '0) ^ (tx_cnt_q != '0));
    assign stop_go = wr_cmd && (reg_wdata[3:0] == 4'hB);
    assign bad_cmd = wr_cmd && !cmd_go && !stop_go;

    i2cm_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(reg_wr && reg_addr == RA_DATA), .wdata(reg_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty));

    i2cm_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(eng_rbyte),
        .pop(reg_rd && reg_addr == RA_DATA), .rdata(rx_head), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty));

    i2cm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_go(cmd_go), .stop_go(stop_go),
        .rx_cnt(rx_cnt_q), .tx_cnt(tx_cnt_q), .adr_first(adr1_q), .adr_second(adr2_q),
        .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full),
        .bus_done(eng_done), .bus_nak(eng_nak), .bus_arb(eng_arb),
        .busy(busy), .rd_dir(rd_dir), .bus_req(eng_req), .bus_op(op),
        .bus_wbyte(eng_wbyte), .bus_mack(eng_mack), .tx_pop(tx_pop), .rx_push(rx_push),
        .tx_done_cnt(tx_done), .rx_done_cnt(rx_done),
        .ev_mdone(ev_mdone), .ev_stop(ev_stop), .ev_arb(ev_arb),
        .ev_naka(ev_naka), .ev_nakd(ev_nakd));

    assign eng_op = op;

    // queue service levels
    assign tx_sum = (CNT_W+1)'(tx_done) + (CNT_W+1)'(tx_lvl);
    assign tx_svc = busy && !rd_dir && (tx_sum < {1'b0, tx_cnt_q}) && !tx_full;
    assign rx_svc = !rx_empty;

    // event vector and visible status word
    always_comb begin
        ev           = '0;
        ev[SB_MDONE] = ev_mdone;
        ev[SB_STOP]  = ev_stop;
        ev[SB_BADP]  = bad_cmd;
        ev[SB_ARB]   = ev_arb;
        ev[SB_NAKD]  = ev_nakd;
        ev[SB_NAKA]  = ev_naka;
        set_vec           = '0;
        set_vec[11:4]     = ev;
        set_vec[SB_TXSVC] = tx_svc && !svc_q[0];
        set_vec[SB_RXSVC] = rx_svc && !svc_q[1];
        status_w           = '0;
        status_w[11:4]     = st_q;
        status_w[SB_TXSVC] = tx_svc;
        status_w[SB_RXSVC] = rx_svc;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt_q <= '0;
            tx_cnt_q <= '0;
            adr1_q   <= '0;
            adr2_q   <= '0;
            en_q     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_RXCNT: rx_cnt_q <= reg_wdata[CNT_W-1:0];
                RA_TXCNT: if (!busy) tx_cnt_q <= reg_wdata[CNT_W-1:0];
                RA_ADR1:  if (!busy) adr1_q <= reg_wdata[7:0];
                RA_ADR2:  if (!busy) adr2_q <= reg_wdata[7:0];
                RA_IEN:   en_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // sticky status, service edge history and pending interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            svc_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= (st_q & ~((reg_wr && reg_addr == RA_STAT) ? reg_wdata[11:4] : 8'h00)) | ev;
            svc_q  <= {rx_svc, tx_svc};
            pend_q <= (pend_q && !(reg_wr && reg_addr == RA_IPEND && reg_wdata[0]))
                      || |(set_vec & en_q);
        end
    end

    assign irq = pend_q;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMD:    reg_rdata[3] = busy;
            RA_RXCNT:  reg_rdata[CNT_W-1:0] = rx_cnt_q;
            RA_TXCNT:  reg_rdata[CNT_W-1:0] = tx_cnt_q;
            RA_ADR1:   reg_rdata[7:0] = adr1_q;
            RA_ADR2:   reg_rdata[7:0] = adr2_q;
            RA_DATA:   reg_rdata[7:0] = rx_head;
            RA_LEVEL:  begin
                reg_rdata[LVL_W-1:0]   = tx_lvl;
                reg_rdata[8 +: LVL_W]  = rx_lvl;
            end
            RA_STAT:   reg_rdata = status_w;
            RA_IEN:    reg_rdata = en_q;
            RA_IPEND:  reg_rdata[0] = pend_q;
            RA_TXDONE: reg_rdata[CNT_W-1:0] = tx_done;
            RA_RXDONE: reg_rdata[CNT_W-1:0] = rx_done;
            default:   ;
        endcase
    end

    AST_ERR_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q[SB_NAKA]) || $rose(st_q[SB_NAKD]) || $rose(st_q[SB_ARB])) |-> !busy); // R6
    AST_MDONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[SB_MDONE]) |-> !busy && !eng_req); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[SB_STOP]) |-> !busy); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> |($past(set_vec) & $past(en_q))); // R11
endmodule

// File: tb/tb_i2cm_msg_seq.sv
module tb_i2cm_msg_seq;
    import i2cm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, eng_req, eng_mack;
    logic [1:0]  eng_op;
    logic [7:0]  eng_wbyte;
    logic        eng_done, eng_nak, eng_arb;
    logic [7:0]  eng_rbyte;

    int nvec = 0, nfail = 0;
    int nops = 0, base = 0;
    int nak_abs = -1, arb_abs = -1;
    int ops_log [0:511];
    int byte_log[0:511];
    int ack_log [0:511];
    logic       eb, cur_nak, cur_arb;
    logic [7:0] cur_rb;
    int         ecnt;
    logic [15:0] rv;

    i2cm_msg_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_mack(eng_mack), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_arb(eng_arb), .eng_rbyte(eng_rbyte));

    always #2 clk = ~clk;

    // bit-timing engine model: fixed latency, logs every accepted request
    always @(posedge clk) begin
        if (!rst_n) begin
            eb <= 1'b0; ecnt <= 0; eng_done <= 1'b0; eng_nak <= 1'b0;
            eng_arb <= 1'b0; eng_rbyte <= 8'h00;
            cur_nak <= 1'b0; cur_arb <= 1'b0; cur_rb <= 8'h00;
        end else begin
            eng_done <= 1'b0; eng_nak <= 1'b0; eng_arb <= 1'b0;
            if (eb) begin
                if (ecnt == 0) begin
                    eng_done <= 1'b1; eng_nak <= cur_nak; eng_arb <= cur_arb;
                    eng_rbyte <= cur_rb; eb <= 1'b0;
                end else ecnt <= ecnt - 1;
            end else if (eng_req && !eng_done) begin
                eb <= 1'b1; ecnt <= 3;
                ops_log[nops]  = int'(eng_op);
                byte_log[nops] = int'(eng_wbyte);
                ack_log[nops]  = int'(eng_mack);
                cur_nak <= (nops == nak_abs);
                cur_arb <= (nops == arb_abs);
                cur_rb  <= 8'((nops - base) + 192);
                nops = nops + 1;
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        logic [15:0] c;
        for (int i = 0; i < 4000; i++) begin
            rd(RA_CMD, c);
            if (!c[3]) return;
        end
    endtask

    task automatic clr_stat();
        wr(RA_STAT, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(RA_CMD, rv);   chk("R1 busy", rv[3], 0);
        rd(RA_STAT, rv);  chk("R1 status", rv, 0);
        rd(RA_LEVEL, rv); chk("R1 levels", rv, 0);
        chk("R1 irq", irq, 0);

        // R2 R4 write sweep, 7-bit address
        for (int n = 1; n <= 8; n++) begin
            clr_stat();
            for (int k = 0; k < n; k++) wr(RA_DATA, 16'((16 * n + k) & 255));
            wr(RA_RXCNT, 0); wr(RA_TXCNT, 16'(n)); wr(RA_ADR1, 16'hA0);
            base = nops;
            wr(RA_CMD, 16'h8);
            wait_idle();
            chk("R2 op count", nops - base, 2 + n);
            chk("R2 start op", ops_log[base], 0);
            chk("R3 single addr", byte_log[base + 1], 'hA0);
            for (int k = 0; k < n; k++) begin
                chk("R4 op", ops_log[base + 2 + k], 1);
                chk("R4 byte", byte_log[base + 2 + k], (16 * n + k) & 255);
            end
            rd(RA_STAT, rv);   chk("R2 mdone", rv[SB_MDONE], 1);
            rd(RA_TXDONE, rv); chk("R4 txdone", rv, n);
        end

        // R5 R10 read sweep
        for (int n = 1; n <= 8; n++) begin
            clr_stat();
            wr(RA_TXCNT, 0); wr(RA_RXCNT, 16'(n)); wr(RA_ADR1, 16'hA1);
            base = nops;
            wr(RA_CMD, 16'h8);
            wait_idle();
            chk("R5 op count", nops - base, 2 + n);
            for (int k = 0; k < n; k++) begin
                chk("R5 op", ops_log[base + 2 + k], 2);
                chk("R5 mack", ack_log[base + 2 + k], (k != n - 1) ? 1 : 0);
            end
            rd(RA_STAT, rv);  chk("R10 rx service", rv[SB_RXSVC], 1);
            rd(RA_LEVEL, rv); chk("R12 rx level", rv[11:8], n);
            for (int k = 0; k < n; k++) begin
                rd(RA_DATA, rv); chk("R5 data", rv[7:0], 192 + 2 + k);
            end
            rd(RA_RXDONE, rv); chk("R5 rxdone", rv, n);
            rd(RA_STAT, rv);   chk("R10 rx service clear", rv[SB_RXSVC], 0);
        end

        // R3 10-bit address
        clr_stat();
        wr(RA_DATA, 16'h5C); wr(RA_RXCNT, 0); wr(RA_TXCNT, 1);
        wr(RA_ADR1, 16'hF6); wr(RA_ADR2, 16'h34);
        base = nops; wr(RA_CMD, 16'h8); wait_idle();
        chk("R3 op count", nops - base, 4);
        chk("R3 first", byte_log[base + 1], 'hF6);
        chk("R3 second", byte_log[base + 2], 'h34);
        chk("R3 data", byte_log[base + 3], 'h5C);

        // R6 NAK on address (read message)
        clr_stat();
        wr(RA_TXCNT, 0); wr(RA_RXCNT, 2); wr(RA_ADR1, 16'hA1);
        base = nops; nak_abs = base + 1;
        wr(RA_CMD, 16'h8); wait_idle(); nak_abs = -1;
        chk("R6 naka ops", nops - base, 2);
        rd(RA_STAT, rv);
        chk("R6 naka bit", rv[SB_NAKA], 1);
        chk("R6 naka no mdone", rv[SB_MDONE], 0);
        rd(RA_RXDONE, rv); chk("R6 naka rxdone", rv, 0);

        // R6 NAK on data
        clr_stat();
        wr(RA_DATA, 16'h11); wr(RA_DATA, 16'h22);
        wr(RA_RXCNT, 0); wr(RA_TXCNT, 2); wr(RA_ADR1, 16'hA0);
        base = nops; nak_abs = base + 3;
        wr(RA_CMD, 16'h8); wait_idle(); nak_abs = -1;
        chk("R6 nakd ops", nops - base, 4);
        rd(RA_STAT, rv); chk("R6 nakd bit", rv[SB_NAKD], 1);
        rd(RA_TXDONE, rv); chk("R6 nakd txdone", rv, 1);
        rd(RA_LEVEL, rv); chk("R6 nakd txlevel", rv[3:0], 0);

        // R6 arbitration lost at START
        clr_stat();
        wr(RA_TXCNT, 0); wr(RA_RXCNT, 1);
        base = nops; arb_abs = base;
        wr(RA_CMD, 16'h8); wait_idle(); arb_abs = -1;
        chk("R6 arb ops", nops - base, 1);
        rd(RA_STAT, rv); chk("R6 arb bit", rv[SB_ARB], 1);

        // R7 invalid parameters and code
        clr_stat();
        wr(RA_TXCNT, 2); wr(RA_RXCNT, 2); base = nops; wr(RA_CMD, 16'h8);
        repeat (10) @(negedge clk);
        rd(RA_STAT, rv); chk("R7 both counts", rv[SB_BADP], 1);
        chk("R7 both counts no op", nops - base, 0);
        clr_stat();
        wr(RA_TXCNT, 0); wr(RA_RXCNT, 0); wr(RA_CMD, 16'h8);
        repeat (10) @(negedge clk);
        rd(RA_STAT, rv); chk("R7 zero counts", rv[SB_BADP], 1);
        clr_stat();
        wr(RA_RXCNT, 1); wr(RA_CMD, 16'h9);
        repeat (10) @(negedge clk);
        rd(RA_STAT, rv); chk("R7 code 9", rv[SB_BADP], 1);
        rd(RA_CMD, rv);  chk("R7 not busy", rv[3], 0);
        chk("R7 no op", nops - base, 0);

        // R8 stop command
        clr_stat();
        base = nops; wr(RA_CMD, 16'hB); wait_idle();
        chk("R8 stop ops", nops - base, 1);
        chk("R8 stop op code", ops_log[base], 3);
        rd(RA_STAT, rv); chk("R8 stop bit", rv[SB_STOP], 1);

        // R9 extend a read
        clr_stat();
        wr(RA_TXCNT, 0); wr(RA_RXCNT, 2); wr(RA_ADR1, 16'hA1);
        base = nops; wr(RA_CMD, 16'h8); wr(RA_RXCNT, 5); wait_idle();
        chk("R9 op count", nops - base, 7);
        for (int k = 0; k < 5; k++) chk("R9 mack", ack_log[base + 2 + k], (k != 4) ? 1 : 0);
        rd(RA_RXDONE, rv); chk("R9 rxdone", rv, 5);
        for (int k = 0; k < 5; k++) rd(RA_DATA, rv);

        // R11 interrupt mask, pending flag and sticky status
        clr_stat();
        wr(RA_IEN, 16'h0800);
        wr(RA_DATA, 16'h77); wr(RA_RXCNT, 0); wr(RA_TXCNT, 1); wr(RA_ADR1, 16'hA0);
        wr(RA_CMD, 16'h8); wait_idle();
        chk("R11 irq on enabled", irq, 1);
        wr(RA_IPEND, 16'h1);
        chk("R11 irq cleared", irq, 0);
        rd(RA_STAT, rv); chk("R11 sticky", rv[SB_MDONE], 1);
        clr_stat();
        wr(RA_CMD, 16'hB); wait_idle();
        repeat (2) @(negedge clk);
        chk("R11 masked stop", irq, 0);
        wr(RA_STAT, 16'h0200);
        rd(RA_STAT, rv); chk("R11 w1c", rv, 0);
        wr(RA_IEN, 16'h0000);

        // R12 transmit queue full drop
        clr_stat();
        for (int k = 0; k < 9; k++) wr(RA_DATA, 16'(k + 1));
        rd(RA_LEVEL, rv); chk("R12 tx level", rv[3:0], 8);
        wr(RA_RXCNT, 0); wr(RA_TXCNT, 8);
        base = nops; wr(RA_CMD, 16'h8); wait_idle();
        chk("R12 op count", nops - base, 10);
        chk("R12 last byte", byte_log[base + 9], 8);
        rd(RA_LEVEL, rv); chk("R12 tx drained", rv[3:0], 0);

        // R10 transmit service flag
        clr_stat();
        wr(RA_DATA, 16'hA5); wr(RA_TXCNT, 4);
        base = nops; wr(RA_CMD, 16'h8);
        repeat (40) @(negedge clk);
        rd(RA_STAT, rv);   chk("R10 tx service", rv[SB_TXSVC], 1);
        rd(RA_TXDONE, rv); chk("R10 stalled txdone", rv, 1);
        wr(RA_DATA, 16'hA6); wr(RA_DATA, 16'hA7); wr(RA_DATA, 16'hA8);
        rd(RA_STAT, rv);   chk("R10 tx service off", rv[SB_TXSVC], 0);
        wait_idle();
        rd(RA_TXDONE, rv); chk("R10 txdone", rv, 4);
        chk("R10 op count", nops - base, 6);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
        $finish;
    end
endmodule